// File: doc/BRIEF.md
# Programmable Sample Timebase with Overrun Detection

This block paces a slow acquisition loop. It counts edges of a 32.768 kHz reference, which arrives as a one-cycle enable `ref_tick` in the system clock domain. After a programmed number of those edges it raises a pending-sample flag for the host CPU. The period is written as four decimal digits, one digit per byte-wide register write. The host services each sample and then clears the flag. If the next period ends while the flag is still pending, a sticky overrun flag records the missed sample.

The same 4-bit status word also carries two operator stop switches, each synchronized and debounced in reference ticks. Pressing the end-of-scan switch alone requests a pause once the current scan completes. Pressing both switches together requests an immediate abort. The block decodes these two cases onto dedicated outputs.

Top module: `sample_timebase`

## Requirements
- R1: After reset, `status_o` is 0, `pause_o` and `abort_o` are 0, all digit registers hold 0, and the effective period is therefore 3 reference ticks.
- R2: A write to address 0, 1, 2 or 3 loads the units, tens, hundreds or thousands digit respectively. The pending-sample flag (status bit 0) is set on the edge of the N-th reference tick counted after the last digit write, where N is the decimal value of the four digits.
- R3: A written byte whose value is above 9 is stored as the digit 9. A four-digit value below 3 is used as 3, so the period always lies between 3 and 9999 ticks.
- R4: Every digit write restarts the tick count from zero. A reference tick in the same cycle as a digit write is not counted.
- R5: Writing address 4 with data bit 0 set clears status bit 0. If a period ends in the same cycle, the flag stays set.
- R6: Status bit 1 (overrun) is set when a period ends while bit 0 is set and is not being cleared in that cycle. It stays set until a write to address 4 with data bit 1 set. A simultaneous new overrun takes priority over the clear.
- R7: Status bit 2 follows the stop-at-end-of-scan switch and bit 3 the stop-immediately switch. Each input passes two synchronizing flip-flops. The debounced value changes only after the synchronized input has differed from it for DEB_TICKS reference ticks, so a shorter glitch has no effect.
- R8: `pause_o` is 1 only when the debounced end-of-scan switch is pressed and the immediate switch is not. `abort_o` is 1 only when both are pressed. The immediate switch alone drives neither output.
- R9: Writes to addresses 5, 6 and 7 change neither the status word nor the period count.
- R10: System clock cycles without `ref_tick` do not advance the period count or the debounce count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable per reference clock edge |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 8 | Host write data |
| sw_stop_eos | input | 1 | Raw stop-at-end-of-scan switch, 1 = pressed |
| sw_stop_now | input | 1 | Raw stop-immediately switch, 1 = pressed |
| status_o | output | 4 | {stop-now, stop-eos, overrun, sample pending} |
| pause_o | output | 1 | Pause-after-scan request |
| abort_o | output | 1 | Immediate abort request |

## Verification
The assertions check on every cycle that the period count stays below the effective period and that the period stays between 3 and 9999. They also check that a digit write zeroes the count, that the pending flag rises only on a period end, and that overrun rises only on a period end with the flag already pending. Further per-cycle checks confirm that overrun falls only on its clear bit and that a debounced switch changes only on a reference tick. The bench scenarios are needed to show the exact period in ticks for several digit patterns, the digit and range clamping, and the restart on a rewrite. They also show the priority of a period end over a simultaneous clear, the rejection of short switch glitches, the pause/abort decoding, and the lack of any effect from unused addresses.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int NDIG    = 4;
  localparam int DIG_W   = 4;
  localparam int MIN_MOD = 3;
  localparam int MAX_MOD = 10**NDIG - 1;
  localparam int MOD_W   = $clog2(MAX_MOD + 1);
  localparam int NSW     = 2;
  typedef logic [DIG_W-1:0] digit_t;
  typedef logic [MOD_W-1:0] mod_t;
endpackage

// File: rtl/bcd_modulus.sv
module bcd_modulus
  import stb_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              reload_o,
  output mod_t              mod_o
);
  digit_t dig_q [NDIG];
  digit_t dig_in;
  mod_t   acc;

  assign reload_o = wr_en && (wr_addr < ADDR_W'(NDIG));
  assign dig_in   = (wr_data > DATA_W'(9)) ? DIG_W'(9) : wr_data[DIG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NDIG; i++) dig_q[i] <= '0;
    end else if (reload_o) begin
      for (int i = 0; i < NDIG; i++)
        if (wr_addr == ADDR_W'(i)) dig_q[i] <= dig_in;
    end
  end

  // decimal digits to binary, most significant digit first
  always_comb begin
    acc = '0;
    for (int i = NDIG - 1; i >= 0; i--)
      acc = acc * MOD_W'(10) + MOD_W'(dig_q[i]);
  end

  assign mod_o = (acc < MOD_W'(MIN_MOD)) ? MOD_W'(MIN_MOD) : acc;
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import stb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic reload,
  input  mod_t mod_i,
  output logic tc_o,
  output mod_t cnt_o
);
  mod_t cnt_q;
  logic at_end;

  assign at_end = (cnt_q == mod_i - 1'b1);
  assign tc_o   = tick && !reload && at_end;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || reload)  cnt_q <= '0;
    else if (tick) begin
      if (at_end) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/switch_debounce.sv
module switch_debounce #(
  parameter int DEB_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic raw,
  output logic stable_o
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  logic          s1_q, s2_q, stable_q;
  logic [CW-1:0] run_q;

  assign stable_o = stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      stable_q <= 1'b0;
      run_q    <= '0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      if (s2_q == stable_q) run_q <= '0;
      else if (tick) begin
        if (run_q == CW'(DEB_TICKS - 1)) begin
          stable_q <= s2_q;
          run_q    <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sample_timebase.sv
module sample_timebase
  import stb_pkg::*;
#(
  parameter int DEB_TICKS = 16,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int CLR_ADDR  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sw_stop_eos,
  input  logic              sw_stop_now,
  output logic [3:0]        status_o,
  output logic              pause_o,
  output logic              abort_o
);
  logic           digit_wr;
  logic           tc;
  mod_t           mod_val;
  mod_t           cnt_val;
  logic           clr_hit, clr_req, clr_ovr;
  logic           req_q, ovr_q;
  logic [NSW-1:0] sw_raw, sw_db;

  bcd_modulus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mod (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reload_o(digit_wr), .mod_o(mod_val)
  );

  tick_divider u_div (
    .clk(clk), .rst(rst), .tick(ref_tick), .reload(digit_wr),
    .mod_i(mod_val), .tc_o(tc), .cnt_o(cnt_val)
  );

  assign sw_raw = {sw_stop_now, sw_stop_eos};

  for (genvar g = 0; g < NSW; g++) begin : g_sw
    switch_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
      .clk(clk), .rst(rst), .tick(ref_tick), .raw(sw_raw[g]),
      .stable_o(sw_db[g])
    );
  end

  assign clr_hit = wr_en && (wr_addr == ADDR_W'(CLR_ADDR));
  assign clr_req = clr_hit && wr_data[0];
  assign clr_ovr = clr_hit && wr_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (tc)           req_q <= 1'b1;
      else if (clr_req) req_q <= 1'b0;
      if (tc && req_q && !clr_req) ovr_q <= 1'b1;
      else if (clr_ovr)            ovr_q <= 1'b0;
    end
  end

  assign status_o = {sw_db[1], sw_db[0], ovr_q, req_q};
  assign pause_o  = sw_db[0] && !sw_db[1];
  assign abort_o  = sw_db[0] && sw_db[1];
endmodule

// File: rtl/sample_timebase_chk.sv
module sample_timebase_chk
  import stb_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ref_tick,
  input logic       clr_ovr,
  input logic [3:0] status_o,
  input logic       tc,
  input logic       digit_wr,
  input mod_t       mod_val,
  input mod_t       cnt_val
);
  // R3
  mod_range_chk: assert property (@(posedge clk) disable iff (rst)
    mod_val >= MOD_W'(MIN_MOD) && mod_val <= MOD_W'(MAX_MOD));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_val < mod_val);

  // R4
  reload_zero_chk: assert property (@(posedge clk) disable iff (rst)
    digit_wr |=> cnt_val == '0);

  // R5
  req_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[0]) |-> $past(tc));

  // R6
  ovr_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[1]) |-> $past(tc && status_o[0]));

  // R6
  ovr_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o[1]) |-> $past(clr_ovr));

  // R7
  sw_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o[3:2] != $past(status_o[3:2])) |-> $past(ref_tick));
endmodule

bind sample_timebase sample_timebase_chk u_chk (
  .clk(clk), .rst(rst), .ref_tick(ref_tick), .clr_ovr(clr_ovr),
  .status_o(status_o), .tc(tc), .digit_wr(digit_wr),
  .mod_val(mod_val), .cnt_val(cnt_val)
);

// File: tb/sample_timebase_test.sv
module sample_timebase_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 3;

  logic       clk, rst, ref_tick, wr_en, sw_eos, sw_now;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] status;
  logic       pause, abort;

  int errors = 0, checks = 0;
  bit done = 0;
  bit tick_on = 0;
  int tdiv = 0;

  sample_timebase #(.DEB_TICKS(DEB)) uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sw_stop_eos(sw_eos),
    .sw_stop_now(sw_now), .status_o(status), .pause_o(pause), .abort_o(abort)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference tick stream: one tick every third clock while enabled
  always @(posedge clk) begin
    #3;
    if (tick_on) begin
      tdiv++;
      ref_tick = (tdiv % 3 == 0);
    end else begin
      tdiv = 0;
      ref_tick = 0;
    end
  end

  // behavioural reference model
  int md[4];
  int ph, mreq, movr, modv;
  int q1[2], q2[2], db[2], run[2];
  bit m_tc, m_dw, m_cr, m_co;
  int raw_v[2];

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) md[k] = 0;
      ph = 0; mreq = 0; movr = 0;
      for (int k = 0; k < 2; k++) begin q1[k] = 0; q2[k] = 0; db[k] = 0; run[k] = 0; end
    end else begin
      modv = md[3]*1000 + md[2]*100 + md[1]*10 + md[0];
      if (modv < 3) modv = 3;
      m_dw = wr_en && (wr_addr < 4);
      m_tc = 0;
      if (m_dw) ph = 0;
      else if (ref_tick) begin
        if (ph == modv - 1) begin m_tc = 1; ph = 0; end
        else ph++;
      end
      if (m_dw) md[wr_addr[1:0]] = (wr_data > 9) ? 9 : int'(wr_data);
      m_cr = wr_en && wr_addr == 4 && wr_data[0];
      m_co = wr_en && wr_addr == 4 && wr_data[1];
      if (m_tc && mreq != 0 && !m_cr) movr = 1;
      else if (m_co) movr = 0;
      if (m_tc) mreq = 1;
      else if (m_cr) mreq = 0;
      raw_v[0] = int'(sw_eos); raw_v[1] = int'(sw_now);
      for (int k = 0; k < 2; k++) begin
        if (q2[k] != db[k]) begin
          if (ref_tick) begin
            run[k]++;
            if (run[k] == DEB) begin db[k] = q2[k]; run[k] = 0; end
          end
        end else run[k] = 0;
        q2[k] = q1[k];
        q1[k] = raw_v[k];
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(status[0]) == mreq, "R5 pending flag vs model", int'(status[0]), mreq);
      check(int'(status[1]) == movr, "R6 overrun flag vs model", int'(status[1]), movr);
      check(int'(status[3:2]) == db[1]*2 + db[0], "R7 switch bits vs model",
            int'(status[3:2]), db[1]*2 + db[0]);
      check(int'(pause) == ((db[0] == 1 && db[1] == 0) ? 1 : 0) &&
            int'(abort) == ((db[0] == 1 && db[1] == 1) ? 1 : 0),
            "R8 pause/abort vs model", int'({pause, abort}),
            ((db[0] == 1 && db[1] == 0) ? 2 : 0) + ((db[0] == 1 && db[1] == 1) ? 1 : 0));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic setmod(input logic [7:0] d3, input logic [7:0] d2,
                        input logic [7:0] d1, input logic [7:0] d0);
    tick_on = 0;
    idle(2);
    wr(0, d0); wr(1, d1); wr(2, d2); wr(3, d3);
    wr(4, 8'h03);
  endtask

  task automatic measure(output int n);
    int guard;
    n = 0; guard = 0;
    tick_on = 1;
    while (guard < 40000) begin
      @(posedge clk);
      if (ref_tick) n++;
      @(negedge clk);
      guard++;
      if (status[0]) break;
    end
    tick_on = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic [3:0] snap;
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; sw_eos = 0; sw_now = 0; ref_tick = 0;
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1
    check(status == 4'h0 && !pause && !abort, "R1 reset outputs", int'(status), 0);
    measure(n);
    check(n == 3, "R1 default period", n, 3);

    // R2 periods for several digit patterns
    setmod(0, 0, 0, 5);  measure(n); check(n == 5, "R2 period 0005", n, 5);
    setmod(0, 0, 1, 0);  measure(n); check(n == 10, "R2 period 0010", n, 10);
    setmod(1, 2, 3, 4);  measure(n); check(n == 1234, "R2 period 1234", n, 1234);
    setmod(9, 9, 9, 9);  measure(n); check(n == 9999, "R3 upper period 9999", n, 9999);

    // R3 clamping
    setmod(0, 0, 0, 8'h0F); measure(n); check(n == 9, "R3 digit above 9 clamps", n, 9);
    setmod(0, 0, 0, 8'h2A); measure(n); check(n == 9, "R3 byte 0x2A clamps", n, 9);
    setmod(0, 0, 0, 0);  measure(n); check(n == 3, "R3 zero clamps to 3", n, 3);
    setmod(0, 0, 0, 2);  measure(n); check(n == 3, "R3 two clamps to 3", n, 3);

    // R4 rewrite restarts the count
    setmod(0, 0, 0, 5);
    tick_on = 1;
    n = 0;
    while (n < 3) begin @(posedge clk); if (ref_tick) n++; end
    #2; tick_on = 0;
    idle(2);
    wr(0, 8'h05);
    measure(n); check(n == 5, "R4 full period after rewrite", n, 5);

    // R10 no ticks, no progress
    setmod(0, 0, 0, 3);
    idle(60);
    @(negedge clk);
    check(status[0] == 1'b0, "R10 idle clocks without ticks", int'(status[0]), 0);

    // R6 overrun then clears
    tick_on = 1; idle(40); tick_on = 0; idle(3);
    @(negedge clk);
    check(status[1:0] == 2'b11, "R6 overrun after missed sample", int'(status[1:0]), 3);
    wr(4, 8'h02);
    @(negedge clk);
    check(status[1:0] == 2'b01, "R6 overrun clear keeps pending", int'(status[1:0]), 1);
    wr(4, 8'h01);
    @(negedge clk);
    check(status[1:0] == 2'b00, "R5 pending clear", int'(status[1:0]), 0);

    // R9 unused addresses
    tick_on = 1; idle(20); tick_on = 0; idle(3);
    @(negedge clk); snap = status;
    wr(5, 8'hFF); wr(6, 8'h03); wr(7, 8'hFF);
    @(negedge clk);
    check(status == snap, "R9 unused address writes", int'(status), int'(snap));

    // R7 / R8 switches
    setmod(0, 0, 0, 9);
    tick_on = 1;
    sw_eos = 1; idle(40); @(negedge clk);
    check(status[2] == 1'b1, "R7 eos debounced high", int'(status[2]), 1);
    check(pause && !abort, "R8 eos alone pauses", int'({pause, abort}), 2);
    sw_now = 1; idle(40); @(negedge clk);
    check(!pause && abort, "R8 both switches abort", int'({pause, abort}), 1);
    sw_eos = 0; idle(40); @(negedge clk);
    check(status[3:2] == 2'b10 && !pause && !abort, "R8 stop-now alone",
          int'({status[3:2], pause, abort}), 8);
    sw_now = 0; idle(40);
    sw_eos = 1; idle(1); sw_eos = 0; idle(40); @(negedge clk);
    check(status[2] == 1'b0, "R7 short glitch rejected", int'(status[2]), 0);

    // mixed traffic compared against the model every cycle
    setmod(0, 0, 0, 3);
    tick_on = 1;
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 8)
        0: wr(4, 8'($urandom % 4));
        1: wr(0, 8'($urandom % 16));
        2: begin sw_eos = ~sw_eos; idle(1); end
        3: begin sw_now = ~sw_now; idle(1); end
        4: wr(3'(5 + $urandom % 3), 8'($urandom));
        default: idle(1 + $urandom % 4);
      endcase
    end
    idle(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule